// File: doc/BRIEF.md
# Variable-Page Translation Buffer

This block turns a segmented linear address into a physical address. Before any lookup it looks at the processor mode. In real mode the address passes through unchanged. In protected mode, a data write through a segment that forbids writes is rejected with a general-protection fault, unless the core is in 64-bit mode. With paging off, the address again passes through. With paging on, the address is looked up in a small, fully associative set of entries. Each entry holds its own page size (4 KB, 2 MB or 4 MB), so the offset bits carried over from the linear address depend on the entry that matched. When no entry matches, the block reports a miss fault and returns the linear address, so that a page walker can start.

Translated pages come in from the walker on a fill port. The fill's addresses are aligned down to the page size before they are stored. New entries take the lowest-numbered free slot. When every slot is in use, a round-robin pointer picks the entry to overwrite. One pulse on the invalidate input clears every entry at once.

A small state machine controls each request. In `ST_IDLE` the block accepts a request (transition *accept*). In `ST_EVAL` it evaluates the mode checks and the lookup (transition *evaluate*). In `ST_RESP` it presents the result for one cycle (transition *retire*) and then returns to `ST_IDLE`.

Top module: `xlate_tlb`

## Requirements
- R1: When `mode_pe` is 0 (real mode), the response has fault code 0 (none) and `resp_addr` equal to the request address, whatever the other mode inputs and the entries hold.
- R2: In protected mode with `mode_pg` 0, a request that does not raise a protection fault returns fault code 0 and `resp_addr` equal to the request address, with no lookup (`resp_flags` 0).
- R3: The block returns fault code 1 (general protection) and `resp_addr` 0 (the error code) when all of these hold: protected mode, `mode_long` 0, `req_write` 1, `req_exec` 0 and `seg_writable` 0. This check takes priority over the paging checks. In 64-bit mode, or on an execute request, no such fault arises.
- R4: With paging on and no matching entry, the response has fault code 2 (miss) and `resp_addr` equal to the request address.
- R5: On a hit, `resp_addr` is the stored physical base ORed with the request address masked by (page size − 1). The fill size codes are 0 = 4 KB, 1 = 2 MB, 2 = 4 MB, and 3 acts as 4 KB. `resp_flags` returns the entry's flags.
- R6: A fill stores its virtual and physical addresses aligned down to its page size. Every address inside that page hits, and the first address past the page misses.
- R7: Up to ENTRIES distinct fills after an invalidate are all kept. Each new fill takes a free slot.
- R8: When all slots are full, a fill overwrites the slot chosen by a round-robin pointer. The pointer starts at slot 0 after reset, and each replacement advances it by one, modulo ENTRIES.
- R9: An `inv_all` pulse empties every entry within one cycle. A fill presented in the same cycle is discarded.
- R10: `req_ready` is 1 only in `ST_IDLE`. A request accepted at one edge gives `resp_valid` high for exactly one cycle after the second edge that follows.
- R11: Flags are reported and not enforced. The flag bits are [0] writable, [1] user, [2] global, [3] uncacheable, [4] no-execute. An execute request to a no-execute page, or a write to a read-only page, hits without a fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | ADDR_W | Segmented linear address |
| req_write | input | 1 | Request is a write |
| req_exec | input | 1 | Request is an instruction fetch |
| mode_pe | input | 1 | Protected mode enabled |
| mode_pg | input | 1 | Paging enabled |
| mode_long | input | 1 | Core is in 64-bit mode |
| seg_writable | input | 1 | Current segment permits writes |
| resp_valid | output | 1 | Response present (one cycle) |
| resp_fault | output | 2 | 0 none, 1 general protection, 2 miss |
| resp_addr | output | ADDR_W | Physical address, miss address, or error code |
| resp_flags | output | 5 | Flags of the entry that hit |
| fill_valid | input | 1 | Fill record present |
| fill_vaddr | input | ADDR_W | Virtual address of the filled page |
| fill_paddr | input | ADDR_W | Physical address of the filled page |
| fill_size | input | 2 | Page size code |
| fill_flags | input | 5 | Entry flags |
| inv_all | input | 1 | Invalidate every entry |

## Verification
Two pairs of functions can fall in the same cycle: a fill with an invalidate, and a fill with a full array. The bench drives `fill_valid` and `inv_all` in the same cycle. It then checks that both the new page and an older page miss, which shows that the invalidate won. It also fills a full four-entry array twice and judges the replacement order by which old pages still hit. Around these cases, the bench sweeps every combination of the five mode inputs over a mapped address and an unmapped one. It also sweeps offsets within each page size and computes every expected address arithmetically.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_4M = 2'd2
    } pgsize_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_MISS = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_RESP = 2'd2
    } xstate_e;

    localparam int FLAG_W = 5;

    // Number of offset bits for a page size code; code 3 acts as 4 KB.
    function automatic logic [4:0] page_shift(input logic [1:0] sz);
        case (sz)
            PG_2M:   page_shift = 5'd21;
            PG_4M:   page_shift = 5'd22;
            default: page_shift = 5'd12;
        endcase
    endfunction

endpackage

// File: rtl/xtlb_entry_array.sv
module xtlb_entry_array
    import xtlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_vaddr,
    input  logic [ADDR_W-1:0] wr_paddr,
    input  logic [1:0]        wr_size,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic [ADDR_W-1:0] lk_vaddr,
    output logic [ENTRIES-1:0] valid_vec,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_paddr,
    output logic [FLAG_W-1:0] lk_flags
);

    localparam logic [ADDR_W-1:0] ONES = {ADDR_W{1'b1}};

    logic [ENTRIES-1:0] valid_q;
    logic [ADDR_W-1:0]  vbase_q [ENTRIES];
    logic [ADDR_W-1:0]  pbase_q [ENTRIES];
    logic [1:0]         size_q  [ENTRIES];
    logic [FLAG_W-1:0]  flags_q [ENTRIES];

    logic [ADDR_W-1:0]  wr_mask;
    logic [ENTRIES-1:0] match;
    logic [ADDR_W-1:0]  ent_mask [ENTRIES];

    assign wr_mask   = ~(ONES << page_shift(wr_size));
    assign valid_vec = valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (inv_all) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !inv_all) begin
            vbase_q[wr_idx] <= wr_vaddr & ~wr_mask;
            pbase_q[wr_idx] <= wr_paddr & ~wr_mask;
            size_q[wr_idx]  <= wr_size;
            flags_q[wr_idx] <= wr_flags;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign ent_mask[g] = ~(ONES << page_shift(size_q[g]));
        assign match[g]    = valid_q[g] &&
                             ((lk_vaddr & ~ent_mask[g]) == vbase_q[g]);
    end

    always_comb begin
        lk_hit   = 1'b0;
        lk_paddr = '0;
        lk_flags = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_hit   = 1'b1;
                lk_paddr = lk_paddr | pbase_q[i] | (lk_vaddr & ent_mask[i]);
                lk_flags = lk_flags | flags_q[i];
            end
        end
    end

    // R9
    inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_q == '0));

    // R5
    hit_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (valid_q != '0));

endmodule

// File: rtl/xtlb_alloc.sv
module xtlb_alloc #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_valid,
    input  logic               inv_all,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             full;

    assign full = &valid_vec;

    // Lowest free slot wins: scan downward so the last hit is the lowest.
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end

    assign wr_en  = fill_valid && !inv_all;
    assign wr_idx = full ? rr_q : free_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (wr_en && full) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

    // R7
    free_fill_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !inv_all && !full) |=>
            ($countones(valid_vec) == $past($countones(valid_vec)) + 1));

    // R8
    victim_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !inv_all && full) |=> (&valid_vec));

    // R8
    victim_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !inv_all && full) |=>
            (rr_q == (($past(rr_q) == LAST) ? '0 : $past(rr_q) + 1'b1)));

endmodule

// File: rtl/xtlb_ctrl.sv
module xtlb_ctrl
    import xtlb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_exec,
    input  logic              mode_pe,
    input  logic              mode_pg,
    input  logic              mode_long,
    input  logic              seg_writable,
    output logic [ADDR_W-1:0] lk_vaddr,
    input  logic              lk_hit,
    input  logic [ADDR_W-1:0] lk_paddr,
    input  logic [FLAG_W-1:0] lk_flags,
    output logic              resp_valid,
    output logic [1:0]        resp_fault,
    output logic [ADDR_W-1:0] resp_addr,
    output logic [FLAG_W-1:0] resp_flags
);

    xstate_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic wr_q, ex_q, pe_q, pg_q, lm_q, sw_q;

    fault_e            res_fault;
    logic [ADDR_W-1:0] res_addr;
    logic [FLAG_W-1:0] res_flags;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept, evaluate, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            {wr_q, ex_q, pe_q, pg_q, lm_q, sw_q} <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            addr_q <= req_vaddr;
            wr_q   <= req_write;
            ex_q   <= req_exec;
            pe_q   <= mode_pe;
            pg_q   <= mode_pg;
            lm_q   <= mode_long;
            sw_q   <= seg_writable;
        end
    end

    assign lk_vaddr = addr_q;

    // Ordered checks: mode, segment protection, paging, lookup
    always_comb begin
        res_fault = FLT_NONE;
        res_addr  = addr_q;
        res_flags = '0;
        if (!pe_q) begin
            res_fault = FLT_NONE;
        end else if (!lm_q && wr_q && !ex_q && !sw_q) begin
            res_fault = FLT_GP;
            res_addr  = '0;
        end else if (!pg_q) begin
            res_fault = FLT_NONE;
        end else if (lk_hit) begin
            res_addr  = lk_paddr;
            res_flags = lk_flags;
        end else begin
            res_fault = FLT_MISS;
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_fault <= FLT_NONE;
            resp_addr  <= '0;
            resp_flags <= '0;
        end else if (state_q == ST_EVAL) begin
            resp_fault <= res_fault;
            resp_addr  <= res_addr;
            resp_flags <= res_flags;
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign resp_valid = (state_q == ST_RESP);

    // R10
    resp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R10
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 resp_valid);

    // R1
    real_mode_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !pe_q) |-> (resp_fault == FLT_NONE && resp_addr == addr_q));

    // R3
    long_no_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && lm_q) |-> (resp_fault != FLT_GP));

endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import xtlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_exec,
    input  logic              mode_pe,
    input  logic              mode_pg,
    input  logic              mode_long,
    input  logic              seg_writable,
    output logic              resp_valid,
    output logic [1:0]        resp_fault,
    output logic [ADDR_W-1:0] resp_addr,
    output logic [4:0]        resp_flags,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_vaddr,
    input  logic [ADDR_W-1:0] fill_paddr,
    input  logic [1:0]        fill_size,
    input  logic [4:0]        fill_flags,
    input  logic              inv_all
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_vec;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic [ADDR_W-1:0]  lk_vaddr;
    logic               lk_hit;
    logic [ADDR_W-1:0]  lk_paddr;
    logic [FLAG_W-1:0]  lk_flags;

    xtlb_alloc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .inv_all    (inv_all),
        .valid_vec  (valid_vec),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx)
    );

    xtlb_entry_array #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_all   (inv_all),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_vaddr  (fill_vaddr),
        .wr_paddr  (fill_paddr),
        .wr_size   (fill_size),
        .wr_flags  (fill_flags),
        .lk_vaddr  (lk_vaddr),
        .valid_vec (valid_vec),
        .lk_hit    (lk_hit),
        .lk_paddr  (lk_paddr),
        .lk_flags  (lk_flags)
    );

    xtlb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .req_write    (req_write),
        .req_exec     (req_exec),
        .mode_pe      (mode_pe),
        .mode_pg      (mode_pg),
        .mode_long    (mode_long),
        .seg_writable (seg_writable),
        .lk_vaddr     (lk_vaddr),
        .lk_hit       (lk_hit),
        .lk_paddr     (lk_paddr),
        .lk_flags     (lk_flags),
        .resp_valid   (resp_valid),
        .resp_fault   (resp_fault),
        .resp_addr    (resp_addr),
        .resp_flags   (resp_flags)
    );

endmodule

// File: tb/xlate_tlb_tb.sv
module xlate_tlb_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [AW-1:0] req_vaddr = '0;
    logic req_write = 1'b0, req_exec = 1'b0;
    logic mode_pe = 1'b0, mode_pg = 1'b0, mode_long = 1'b0, seg_writable = 1'b0;
    logic resp_valid;
    logic [1:0] resp_fault;
    logic [AW-1:0] resp_addr;
    logic [4:0] resp_flags;
    logic fill_valid = 1'b0;
    logic [AW-1:0] fill_vaddr = '0, fill_paddr = '0;
    logic [1:0] fill_size = '0;
    logic [4:0] fill_flags = '0;
    logic inv_all = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlate_tlb #(.ENTRIES(N), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_exec(req_exec),
        .mode_pe(mode_pe), .mode_pg(mode_pg), .mode_long(mode_long),
        .seg_writable(seg_writable),
        .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_addr(resp_addr), .resp_flags(resp_flags),
        .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr),
        .fill_size(fill_size), .fill_flags(fill_flags), .inv_all(inv_all)
    );

    function automatic logic [AW-1:0] pmask(input logic [1:0] sz);
        case (sz)
            2'd1:    pmask = 32'h001F_FFFF;
            2'd2:    pmask = 32'h003F_FFFF;
            default: pmask = 32'h0000_0FFF;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_fill(input logic [AW-1:0] va, input logic [AW-1:0] pa,
                           input logic [1:0] sz, input logic [4:0] fl, input bit inv);
        @(negedge clk);
        fill_valid = 1'b1; fill_vaddr = va; fill_paddr = pa;
        fill_size = sz; fill_flags = fl; inv_all = inv;
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0; inv_all = 1'b0;
    endtask

    task automatic do_inv();
        @(negedge clk);
        inv_all = 1'b1;
        @(posedge clk);
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    task automatic do_req(input string tag, input logic [AW-1:0] va,
                          input bit wr, input bit ex, input bit pe, input bit pg,
                          input bit lm, input bit sw,
                          input logic [1:0] efault, input logic [AW-1:0] eaddr,
                          input logic [4:0] eflags);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_exec = ex;
        mode_pe = pe; mode_pg = pg; mode_long = lm; seg_writable = sw;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (req_ready !== 1'b0) begin
            errors++;
            $display("FAIL R10 busy ready actual=%b expected=0", req_ready);
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " valid"}, 64'(resp_valid), 64'd1);
        check({tag, " fault"}, 64'(resp_fault), 64'(efault));
        check({tag, " addr"},  64'(resp_addr),  64'(eaddr));
        check({tag, " flags"}, 64'(resp_flags), 64'(eflags));
        @(posedge clk);
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] mva, mpa, uva;
        logic [AW-1:0] vb [3];
        logic [AW-1:0] pb [3];
        logic [1:0]    sz [3];

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check("R10 reset ready", 64'(req_ready), 64'd1);
        check("R10 reset resp_valid", 64'(resp_valid), 64'd0);
        rst_n = 1'b1;

        // Mode sweep over one mapped and one unmapped address (R1 R2 R3 R4 R5)
        mva = 32'h0040_3123; mpa = 32'h0ABC_D000; uva = 32'h0090_0456;
        do_fill(32'h0040_3FFF, mpa | 32'h0000_0777, 2'd0, 5'b00011, 1'b0);
        for (int m = 0; m < 64; m++) begin
            bit pe, pg, lm, wr, sw, mapped;
            logic [AW-1:0] va, ea;
            logic [1:0] ef;
            logic [4:0] efl;
            string tag;
            pe = m[0]; pg = m[1]; lm = m[2]; wr = m[3]; sw = m[4]; mapped = !m[5];
            va = mapped ? mva : uva;
            efl = 5'd0;
            if (!pe) begin
                ef = 2'd0; ea = va; tag = "R1 real";
            end else if (!lm && wr && !sw) begin
                ef = 2'd1; ea = '0; tag = "R3 gp";
            end else if (!pg) begin
                ef = 2'd0; ea = va; tag = "R2 nopaging";
            end else if (mapped) begin
                ef = 2'd0; ea = mpa | (va & 32'hFFF); efl = 5'b00011; tag = "R5 hit";
            end else begin
                ef = 2'd2; ea = va; tag = "R4 miss";
            end
            do_req(tag, va, wr, 1'b0, pe, pg, lm, sw, ef, ea, efl);
        end

        // Page-size sweep (R5 R6)
        do_inv();
        vb[0] = 32'h1234_5000; pb[0] = 32'h8765_4000; sz[0] = 2'd0;
        vb[1] = 32'h3440_0000; pb[1] = 32'h4000_0000; sz[1] = 2'd1;
        vb[2] = 32'h5640_0000; pb[2] = 32'h9900_0000; sz[2] = 2'd2;
        do_fill(32'h1234_5678, 32'h8765_4321, 2'd0, 5'b00001, 1'b0);
        do_fill(32'h3456_789A, 32'h4000_1234, 2'd1, 5'b00010, 1'b0);
        do_fill(32'h5678_9ABC, 32'h9912_3456, 2'd2, 5'b00100, 1'b0);
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 6; k++) begin
                logic [AW-1:0] off, va;
                off = (32'(k) * 32'h0013_5791 + 32'(k)) & pmask(sz[p]);
                if (k == 5) off = pmask(sz[p]);
                va = vb[p] | off;
                do_req("R5 R6 size hit", va, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1,
                       2'd0, pb[p] | off, 5'(1 << p));
            end
            do_req("R6 past page", vb[p] + pmask(sz[p]) + 1, 1'b0, 1'b0, 1'b1, 1'b1,
                   1'b0, 1'b1, 2'd2, vb[p] + pmask(sz[p]) + 1, 5'd0);
        end

        // Flags reported, not enforced (R11); execute exempt from R3
        do_inv();
        do_fill(32'h0070_0000, 32'h0123_4000, 2'd0, 5'b10000, 1'b0);
        do_req("R11 exec on no-exec page", 32'h0070_0010, 1'b1, 1'b1, 1'b1, 1'b1,
               1'b0, 1'b0, 2'd0, 32'h0123_4010, 5'b10000);
        do_req("R11 write to read-only page", 32'h0070_0020, 1'b1, 1'b0, 1'b1, 1'b1,
               1'b0, 1'b1, 2'd0, 32'h0123_4020, 5'b10000);

        // Free list then round-robin victims (R7 R8)
        do_inv();
        for (int i = 0; i < N + 2; i++)
            do_fill(32'h0100_0000 + 32'(i) * 32'h1000, 32'h0200_0000 + 32'(i) * 32'h1000,
                    2'd0, 5'd0, 1'b0);
        for (int i = 0; i < N + 2; i++) begin
            logic [AW-1:0] va;
            va = 32'h0100_0000 + 32'(i) * 32'h1000 + 32'h44;
            if (i < 2)
                do_req("R8 victim evicted", va, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1,
                       2'd2, va, 5'd0);
            else
                do_req("R7 R8 kept", va, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1,
                       2'd0, 32'h0200_0000 + 32'(i) * 32'h1000 + 32'h44, 5'd0);
        end

        // Fill and invalidate in the same cycle (R9)
        do_fill(32'h0600_0000, 32'h0700_0000, 2'd0, 5'd0, 1'b1);
        do_req("R9 same-cycle fill dropped", 32'h0600_0004, 1'b0, 1'b0, 1'b1, 1'b1,
               1'b0, 1'b1, 2'd2, 32'h0600_0004, 5'd0);
        do_req("R9 old entry gone", 32'h0100_2044, 1'b0, 1'b0, 1'b1, 1'b1,
               1'b0, 1'b1, 2'd2, 32'h0100_2044, 5'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule